// File: doc/BRIEF.md
# Sample Frame Serializer with Frame-Sync Timing

This block produces the serial output side of a multi-channel sampling front end. It runs from a master clock and derives a continuous serial clock from it. Once per sample interval it sends one 16-bit word for each enabled channel. Each word is announced by a one-slot frame-sync pulse. The words go out back to back, so the pulse for every word after the first overlaps the last bit of the word before it.

After reset the sample interval is a fixed 2048 master clocks, which gives slow controllers time to start talking to the device. A write to the rate register selects one of four interval lengths. The new length applies from the next interval boundary.

Channel 1 is always sent, because its frame sync marks the start of each interval. In mixed mode the top bit of every outgoing word is cleared to tag it as data.

Top module: `samp_frame_tx`

## Requirements
- R1: While `rst_n` is low, `sclk`, `sdofs` and `sdo` are all low.
- R2: Until `rate_wr` has been pulsed for the first time, every sample interval lasts 2048 master clocks, measured from one interval-start frame sync to the next.
- R3: A `rate_wr` pulse stores `rate_code`. Code c sets the interval to 256·2^c master clocks, so 0→256, 1→512, 2→1024 and 3→2048. The new length applies from the first interval that starts after the write, and the interval in progress keeps its length.
- R4: `sclk` has a period of two master clocks and runs without gaps. `sdofs` and `sdo` change only together with a rising edge of `sclk`, so a receiver can sample them on the falling edge.
- R5: Each interval begins with a bit slot in which `sdofs` is high for exactly one `sclk` cycle. That slot comes just before the first bit of the first word.
- R6: For each word after the first, `sdofs` is high during the last bit of the previous word. It is never high inside a word at any other point.
- R7: Words are 16 bits, sent MSB first. There is one word per enabled channel, in ascending channel order. Bit i of `ch_en` enables channel i+1, and channel i+1's sample is `samples[16i+15:16i]`.
- R8: Channel 1 is sent in every interval, whatever the value of `ch_en[0]`.
- R9: When `mixed_mode` is 1, bit 15 of every word is sent as 0 and bits 14..0 come from the sample. When it is 0, all 16 bits come from the sample.
- R10: `ch_en`, `samples` and `mixed_mode` are captured at the start of each interval. A change during an interval only affects the following interval.
- R11: `sdo` is low in every bit slot that carries no word bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | One-cycle pulse that stores `rate_code` |
| rate_code | input | RATE_W | Interval length code |
| ch_en | input | NCH | Channel enables; bit 0 is channel 1 |
| samples | input | NCH*WORD_W | Sample words, channel 1 in the low bits |
| mixed_mode | input | 1 | Clear the MSB of each outgoing word |
| sclk | output | 1 | Serial clock |
| sdofs | output | 1 | Frame sync, high for one serial clock slot |
| sdo | output | 1 | Serial data, MSB first |

## Verification
A wrong interval counter or a latched rate code shows up as a wrong spacing between interval-start frame syncs. This appears at the second boundary after the fault, up to 2048 master clocks later. A broken channel-compaction or bit-index decode corrupts the very next word, which a falling-edge receiver catches within 16 slots. A frame sync out of place shows at once as a pulse inside a word, or as a word that arrives with no pulse before it. A snapshot taken at the wrong moment makes the words of an interval follow inputs that were changed after the interval began.

// File: rtl/samp_frame_pkg.sv
package samp_frame_pkg;

  // Interval length in master clocks for a rate code.
  function automatic int unsigned interval_len(input int unsigned code,
                                               input int unsigned base);
    return base << code;
  endfunction

  // Outgoing bit after data tagging: the word MSB is cleared in mixed mode.
  function automatic logic tag_bit(input logic raw, input logic mixed,
                                   input logic is_msb);
    return raw & ~(mixed & is_msb);
  endfunction

  // Number of bit slots one interval needs: one lead slot plus the words.
  function automatic int unsigned slots_needed(input int unsigned words,
                                               input int unsigned width);
    return 1 + words * width;
  endfunction

endpackage

// File: rtl/sft_rate_timer.sv
module sft_rate_timer #(
  parameter int unsigned BASE_DIV = 256,
  parameter int unsigned RATE_W   = 2,
  parameter int unsigned CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_code,
  output logic [CNT_W-1:0]  tick,
  output logic              interval_start
);
  import samp_frame_pkg::*;

  localparam int unsigned PW = CNT_W + 1;
  localparam logic [RATE_W-1:0] DEF_CODE = '1;

  logic [RATE_W-1:0] code_q;
  logic [PW-1:0]     len_q;
  logic [CNT_W-1:0]  tick_q;
  logic              wrap;

  assign wrap = ({1'b0, tick_q} == (len_q - PW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= DEF_CODE;
      len_q  <= PW'(interval_len(32'(DEF_CODE), BASE_DIV));
      tick_q <= '0;
    end else begin
      if (rate_wr) code_q <= rate_code;
      if (wrap) begin
        tick_q <= '0;
        len_q  <= PW'(interval_len(32'(code_q), BASE_DIV));
      end else begin
        tick_q <= tick_q + CNT_W'(1);
      end
    end
  end

  assign tick           = tick_q;
  assign interval_start = (tick_q == '0);

endmodule

// File: rtl/sft_bit_clock.sv
module sft_bit_clock #(
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned SCLK_DIV = 2
) (
  input  logic [CNT_W-1:0] tick,
  output logic [CNT_W-1:0] slot,
  output logic             sclk_lvl,
  output logic             slot_end
);
  localparam logic [CNT_W-1:0] DIV  = CNT_W'(SCLK_DIV);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(SCLK_DIV / 2);

  logic [CNT_W-1:0] phase;

  assign phase    = tick % DIV;
  assign slot     = tick / DIV;
  assign sclk_lvl = (phase < HALF);
  assign slot_end = (phase == (DIV - CNT_W'(1)));

endmodule

// File: rtl/sft_word_seq.sv
module sft_word_seq #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  interval_start,
  input  logic [CNT_W-1:0]      slot,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH*WORD_W-1:0] samples,
  input  logic                  mixed,
  output logic                  fs_c,
  output logic                  bit_c,
  output logic                  mix_msb_c
);
  import samp_frame_pkg::*;

  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned N_W  = $clog2(NCH + 1);
  localparam int unsigned B_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [NCH-1:0]    en_q;
  logic              mix_q;
  logic [WORD_W-1:0] samp_q [NCH];

  // Channel 1 is forced on in the captured enable set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= NCH'(1);
      mix_q <= 1'b0;
    end else if (interval_start) begin
      en_q  <= ch_en | NCH'(1);
      mix_q <= mixed;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              samp_q[g] <= '0;
      else if (interval_start) samp_q[g] <= samples[g*WORD_W +: WORD_W];
    end
  end

  // Compact the enabled channels into transmit order.
  logic [CH_W-1:0] order [NCH];
  logic [N_W-1:0]  n_words;

  always_comb begin
    n_words = '0;
    for (int i = 0; i < NCH; i++) order[i] = '0;
    for (int i = 0; i < NCH; i++) begin
      if (en_q[i]) begin
        order[n_words] = CH_W'(i);
        n_words        = n_words + N_W'(1);
      end
    end
  end

  // Slot decode: slot 0 leads, slot 1+16k+j carries bit 15-j of word k.
  int unsigned       s_u, pos_u, widx_u, bidx_u;
  logic              in_data, is_msb, raw;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    s_u      = 32'(slot);
    pos_u    = (s_u == 0) ? 0 : s_u - 1;
    widx_u   = pos_u / WORD_W;
    bidx_u   = WORD_W - 1 - (pos_u % WORD_W);
    in_data  = (s_u != 0) && (s_u < slots_needed(32'(n_words), WORD_W));
    fs_c     = ((s_u % WORD_W) == 0) && ((s_u / WORD_W) < 32'(n_words));
    sel_word = (widx_u < NCH) ? samp_q[order[CH_W'(widx_u)]] : '0;
    raw      = sel_word[B_W'(bidx_u)];
    is_msb   = (bidx_u == WORD_W - 1);
    bit_c    = in_data & tag_bit(raw, mix_q, is_msb);
    mix_msb_c = in_data & mix_q & is_msb;
  end

endmodule

// File: rtl/samp_frame_tx.sv
module samp_frame_tx #(
  parameter int unsigned NCH      = 6,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SCLK_DIV = 2,
  parameter int unsigned BASE_DIV = 256,
  parameter int unsigned RATE_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rate_wr,
  input  logic [RATE_W-1:0]     rate_code,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH*WORD_W-1:0] samples,
  input  logic                  mixed_mode,
  output logic                  sclk,
  output logic                  sdofs,
  output logic                  sdo
);
  localparam int unsigned MAX_LEN = BASE_DIV << ((1 << RATE_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] slot;
  logic             interval_start;
  logic             sclk_lvl;
  logic             slot_end;
  logic             fs_c;
  logic             bit_c;
  logic             mix_msb_c;

  sft_rate_timer #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_code(rate_code),
    .tick(tick), .interval_start(interval_start)
  );

  sft_bit_clock #(.CNT_W(CNT_W), .SCLK_DIV(SCLK_DIV)) u_bclk (
    .tick(tick), .slot(slot), .sclk_lvl(sclk_lvl), .slot_end(slot_end)
  );

  sft_word_seq #(.NCH(NCH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .interval_start(interval_start), .slot(slot),
    .ch_en(ch_en), .samples(samples), .mixed(mixed_mode),
    .fs_c(fs_c), .bit_c(bit_c), .mix_msb_c(mix_msb_c)
  );

  // All three pins leave through flops so they move together on one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      sdofs <= 1'b0;
      sdo   <= 1'b0;
    end else begin
      sclk  <= sclk_lvl;
      sdofs <= fs_c;
      sdo   <= bit_c;
    end
  end

endmodule

// File: rtl/samp_frame_tx_chk.sv
module samp_frame_tx_chk #(
  parameter int unsigned BASE_DIV = 256,
  parameter int unsigned RATE_W   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic rate_wr,
  input logic interval_start,
  input logic slot_end,
  input logic mix_msb_c,
  input logic sclk,
  input logic sdofs,
  input logic sdo
);
  localparam int unsigned DEF_LEN = BASE_DIV << ((1 << RATE_W) - 1);

  logic [31:0] len_cnt;
  logic        started, seen_wr, prev_def;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_cnt  <= '0;
      started  <= 1'b0;
      seen_wr  <= 1'b0;
      prev_def <= 1'b1;
    end else begin
      if (rate_wr) seen_wr <= 1'b1;
      if (interval_start) begin
        len_cnt  <= 32'd1;
        started  <= 1'b1;
        prev_def <= !seen_wr;
      end else begin
        len_cnt <= len_cnt + 32'd1;
      end
    end
  end

  function automatic logic legal_len(input logic [31:0] n);
    for (int c = 0; c < (1 << RATE_W); c++)
      if (n == 32'(BASE_DIV << c)) return 1'b1;
    return 1'b0;
  endfunction

  a_r2_default_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_start && started && prev_def) |-> (len_cnt == 32'(DEF_LEN)));

  a_r3_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_start && started) |-> legal_len(len_cnt));

  a_r4_fs_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdofs != $past(sdofs)) |-> (sclk && !$past(sclk)));

  a_r4_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> (sclk && !$past(sclk)));

  a_r5_fs_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    interval_start |=> sdofs);

  a_r5_fs_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_end) && sdofs) |=> !sdofs);

  a_r9_mixed_msb: assert property (@(posedge clk) disable iff (!rst_n)
    mix_msb_c |=> !sdo);

endmodule

bind samp_frame_tx samp_frame_tx_chk #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .interval_start(interval_start),
  .slot_end(slot_end), .mix_msb_c(mix_msb_c), .sclk(sclk), .sdofs(sdofs), .sdo(sdo)
);

// File: tb/samp_frame_tx_tb.sv
`timescale 1ns/1ps
module samp_frame_tx_tb;
  localparam int NCH = 6;
  localparam int WW  = 16;
  localparam int N_INTERVALS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_wr = 1'b0;
  logic [1:0] rate_code = '0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH*WW-1:0] samples = '0;
  logic mixed_mode = 1'b0;
  logic sclk, sdofs, sdo;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  samp_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_code(rate_code),
    .ch_en(ch_en), .samples(samples), .mixed_mode(mixed_mode),
    .sclk(sclk), .sdofs(sdofs), .sdo(sdo)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Interval length as the requirements state it.
  function automatic int exp_interval(input bit written, input int code);
    if (!written) return 2048;
    return 256 * (2 ** code);
  endfunction

  logic [15:0] exp_w [NCH];
  int exp_n;
  bit exp_mix, exp_ch1_off;
  bit written = 0;
  int cur_code = 0;

  task automatic build_exp();
    exp_n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (c == 0 || ch_en[c]) begin
        exp_w[exp_n] = mixed_mode ? {1'b0, samples[c*WW +: 15]} : samples[c*WW +: WW];
        exp_n++;
      end
    end
    exp_mix = mixed_mode;
    exp_ch1_off = !ch_en[0];
  endtask

  task automatic rand_samples(input bit msb_set);
    samples = {$urandom, $urandom, $urandom};
    if (msb_set)
      for (int c = 0; c < NCH; c++) samples[c*WW + 15] = 1'b1;
  endtask

  // Sets inputs for interval k; called right after interval k-1 has started.
  task automatic stimulus(input int k);
    if (k == 1) begin
      ch_en = 6'b111110; mixed_mode = 1'b1; rand_samples(1'b1);
    end else if (k == 2) begin
      ch_en = 6'b111111; mixed_mode = 1'b0; rand_samples(1'b0);
    end else if (k == 3) begin
      rate_code = 2'd0; rate_wr = 1'b1; written = 1; cur_code = 0;
      ch_en = 6'b111111; mixed_mode = 1'b1; rand_samples(1'b1);
    end else begin
      if ($urandom % 3 == 0) begin
        cur_code = int'($urandom % 4);
        if (cur_code == 3 && ($urandom % 2 == 0)) cur_code = 1;
        rate_code = 2'(cur_code); rate_wr = 1'b1; written = 1;
      end
      ch_en = NCH'($urandom);
      mixed_mode = 1'($urandom);
      rand_samples(1'($urandom));
    end
  endtask

  initial begin
    int t, t_start, t_last, exp_len, n_int, bits_left, widx;
    bit prev_sclk, prev_sdofs, prev_sdo, in_word, rise;
    logic [15:0] shreg;
    string tag;
    void'($urandom(32'd20240611));
    ch_en = 6'b000000;
    mixed_mode = 1'b0;
    rand_samples(1'b1);

    // R1: quiet outputs while reset is held
    repeat (5) begin
      @(negedge clk);
      check(!sclk && !sdofs && !sdo, "R1", "outputs in reset",
            {sclk, sdofs, sdo}, 0);
    end
    rst_n = 1'b1;

    t = 0; t_start = -1; t_last = 0; exp_len = 0; n_int = 0;
    bits_left = 0; widx = 0; shreg = '0;
    prev_sclk = 0; prev_sdofs = 0; prev_sdo = 0;

    while (n_int < N_INTERVALS) begin
      @(negedge clk);
      t++;
      rate_wr = 1'b0;
      if (t > 190000 || (t - t_last) > 2200) begin
        check(0, "R2", "watchdog expired", t, t_last);
        break;
      end
      rise = sclk && !prev_sclk;
      // R4: continuous two-cycle serial clock, pins move only with its rise
      if (t > 1) check(sclk != prev_sclk, "R4", "sclk toggle", sclk, !prev_sclk);
      check(((sdofs == prev_sdofs) && (sdo == prev_sdo)) || rise, "R4",
            "change away from sclk rise", {sdofs, sdo}, {prev_sdofs, prev_sdo});
      if (rise) begin
        in_word = (bits_left > 0);
        if (in_word) begin
          shreg = {shreg[14:0], sdo};
          bits_left--;
          if (bits_left == 0) begin
            if (widx < exp_n) begin
              tag = (widx == 0 && exp_ch1_off) ? "R8" : (exp_mix ? "R9 R10" : "R7 R10");
              check(shreg == exp_w[widx], tag, "word value", shreg, exp_w[widx]);
            end else begin
              check(0, "R7", "extra word", widx, exp_n);
            end
            widx++;
          end
        end else begin
          check(sdo == 1'b0, "R11", "idle slot data", sdo, 0);
        end
        if (sdofs) begin
          if (in_word && bits_left == 0) begin
            bits_left = 16;                       // R6 overlap with last bit
          end else if (!in_word) begin
            if (t_start >= 0) begin
              check((t - t_start) == exp_len, written ? "R3" : "R2",
                    "interval length", t - t_start, exp_len);
              check(widx == exp_n, "R7", "words per interval", widx, exp_n);
            end
            t_start = t; t_last = t;
            exp_len = exp_interval(written, cur_code);
            build_exp();
            widx = 0; bits_left = 16;
            n_int++;
            stimulus(n_int);
          end else begin
            check(0, "R6", "frame sync inside word", bits_left, 0);
          end
        end else if (in_word && bits_left == 0 && widx < exp_n) begin
          check(0, "R6", "missing frame sync for next word", widx, exp_n);
        end else if (!in_word && t_start < 0) begin
          check(0, "R5", "first slot without frame sync", sdofs, 1);
        end
      end
      prev_sclk = sclk; prev_sdofs = sdofs; prev_sdo = sdo;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule